// File: doc/BRIEF.md
# Sliding-Window Jet Clusterer

The clusterer turns one crossing's grid of calorimeter tower energies into a list of jet candidates. Each tower value already holds the electromagnetic plus hadronic transverse energy of that tower. The block first folds every aligned 2x2 tower block into one jet primitive. It then visits every primitive in turn as a candidate seed and slides a square window over the primitive grid in steps of one primitive. The window is 6x6, 8x8 or 10x10 towers, that is 3x3, 4x4 or 5x5 primitives.

A seed becomes a jet when it reaches the seed threshold and is a local maximum among its eight neighbouring primitives. For each jet the block reports the saturated window energy, on a 10-bit scale of about 1 GeV per count. It also reports a seed position resolved to a single tower: the hottest tower inside the seed's 2x2 block. Jets leave one per cycle in raster order, and a done pulse closes the crossing.

A controller with four states sequences the work. IDLE waits for `start`, and in that same edge captures the tower grid, the size select and the threshold. IDLE→LOAD happens on `start`. LOAD registers the primitives and always moves to SCAN. SCAN evaluates one seed cell per cycle. It stays in SCAN (SCAN→SCAN) until the last cell, and then moves on (SCAN→DONE). DONE emits the done pulse and returns to IDLE (DONE→IDLE).

Top module: `jet_clusterer`

## Requirements
- R1: Tower (e,p) sits at bits [(e*NTP+p)*TW +: TW] of `towers`. The primitive at (r,c) is the sum of the towers in rows 2r..2r+1 and columns 2c..2c+1, capped at 1023.
- R2: `win_sel` picks the window: 0 = 3x3 primitives (6x6 towers), 1 = 4x4 (8x8), 2 = 5x5 (10x10). The value 3 behaves as 2.
- R3: Relative to the seed at (r,c), the window spans rows and columns -1..+1 for 3x3, -1..+2 for 4x4, and -2..+2 for 5x5.
- R4: A seed needs a primitive value greater than or equal to `seed_thr`.
- R5: A seed must be strictly greater than each neighbour that comes earlier in raster order, and greater than or equal to each neighbour that comes later. Only the eight adjacent primitives are compared.
- R6: The reported jet energy is the window sum, saturated at 1023.
- R7: Primitives outside the grid count as zero, both in window sums and in neighbour comparisons.
- R8: Jets are reported one per `jet_valid` cycle in raster order of the seed, with the row (eta) as the outer index. The position is the hottest tower of the seed block. On ties the earliest tower in raster order wins.
- R9: `done` pulses for exactly one cycle after the last jet of a crossing, and never in the same cycle as `jet_valid`.
- R10: The grid, size select and threshold are sampled only on an accepted `start`. A `start` while a crossing is in progress, and any input change during it, have no effect.
- R11: Out of reset, `jet_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a crossing (accepted in IDLE only) |
| towers | input | NTE*NTP*TW | Tower energy grid, eta-major |
| win_sel | input | 2 | Window size select |
| seed_thr | input | EW | Seed threshold |
| jet_valid | output | 1 | Jet output valid |
| jet_et | output | EW | Saturated window energy |
| jet_eta | output | $clog2(NTE) | Seed tower row |
| jet_phi | output | $clog2(NTP) | Seed tower column |
| done | output | 1 | End-of-crossing pulse |

## Verification
A wrong window offset or bound shows up at the ports as a wrong `jet_et` on the first jet whose neighbourhood is asymmetric. A wrong neighbour rule shows up as a missing or extra jet. Either fault appears within one crossing, about forty cycles after `start`. A scan counter that skips or repeats a cell breaks the raster order, so a jet arrives with an unexpected position or the done pulse comes too early or too late. A controller that does not guard `start` lets a second pulse trigger a spurious done pulse, seen within a crossing's time.

// File: rtl/jet_pkg.sv
package jet_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LOAD,
        S_SCAN,
        S_DONE
    } clu_state_e;

    localparam logic [1:0] WIN_6  = 2'd0;
    localparam logic [1:0] WIN_8  = 2'd1;
    localparam logic [1:0] WIN_10 = 2'd2;

    // lowest window offset relative to the seed primitive
    function automatic int win_lo(input logic [1:0] sel);
        return (sel == WIN_6 || sel == WIN_8) ? -1 : -2;
    endfunction

    // highest window offset relative to the seed primitive
    function automatic int win_hi(input logic [1:0] sel);
        return (sel == WIN_6) ? 1 : 2;
    endfunction

endpackage

// File: rtl/jet_prim_builder.sv
module jet_prim_builder #(
    parameter int NTE = 12,
    parameter int NTP = 12,
    parameter int TW  = 8,
    parameter int EW  = 10
) (
    input  logic [NTE*NTP*TW-1:0] towers,
    output logic [EW-1:0]         prim [NTE/2][NTP/2],
    output logic [1:0]            sub  [NTE/2][NTP/2]
);
    localparam int NPE  = NTE / 2;
    localparam int NPP  = NTP / 2;
    localparam int EMAX = (1 << EW) - 1;

    for (genvar gr = 0; gr < NPE; gr++) begin : g_row
        for (genvar gc = 0; gc < NPP; gc++) begin : g_col
            logic [TW-1:0] t00, t01, t10, t11, best;
            logic [TW+1:0] quad;
            logic [1:0]    pick;

            assign t00 = towers[((2*gr)*NTP + 2*gc)*TW +: TW];
            assign t01 = towers[((2*gr)*NTP + 2*gc + 1)*TW +: TW];
            assign t10 = towers[((2*gr+1)*NTP + 2*gc)*TW +: TW];
            assign t11 = towers[((2*gr+1)*NTP + 2*gc + 1)*TW +: TW];
            assign quad = {2'b00, t00} + {2'b00, t01} + {2'b00, t10} + {2'b00, t11};

            always_comb begin
                if (32'(quad) > 32'(EMAX)) prim[gr][gc] = EW'(EMAX);
                else                       prim[gr][gc] = EW'(quad);
            end

            // hottest tower of the block; earliest in raster order wins ties
            always_comb begin
                best = t00;
                pick = 2'b00;
                if (t01 > best) begin best = t01; pick = 2'b01; end
                if (t10 > best) begin best = t10; pick = 2'b10; end
                if (t11 > best) begin best = t11; pick = 2'b11; end
                sub[gr][gc] = pick;
            end
        end
    end

endmodule

// File: rtl/jet_window_eval.sv
module jet_window_eval
    import jet_pkg::*;
#(
    parameter int NPE = 6,
    parameter int NPP = 6,
    parameter int EW  = 10,
    parameter int RIW = 3,
    parameter int CIW = 3
) (
    input  logic [EW-1:0]  prim [NPE][NPP],
    input  logic [RIW-1:0] row,
    input  logic [CIW-1:0] col,
    input  logic [1:0]     sel,
    input  logic [EW-1:0]  thr,
    output logic [EW-1:0]  win_sum,
    output logic           is_seed
);
    localparam int AW   = EW + 5;
    localparam int EMAX = (1 << EW) - 1;

    // window sum with out-of-grid primitives counted as zero
    always_comb begin
        int lo, hi, rr, cc;
        logic [AW-1:0] acc;
        lo  = win_lo(sel);
        hi  = win_hi(sel);
        acc = '0;
        for (int dr = -2; dr <= 2; dr++) begin
            for (int dc = -2; dc <= 2; dc++) begin
                rr = int'(row) + dr;
                cc = int'(col) + dc;
                if (dr >= lo && dr <= hi && dc >= lo && dc <= hi &&
                    rr >= 0 && rr < NPE && cc >= 0 && cc < NPP)
                    acc = acc + AW'(prim[RIW'(rr)][CIW'(cc)]);
            end
        end
        if (32'(acc) > 32'(EMAX)) win_sum = EW'(EMAX);
        else                      win_sum = EW'(acc);
    end

    // local-maximum test: strict against earlier neighbours, inclusive against later
    always_comb begin
        int rr, cc;
        logic [EW-1:0] sv, nv;
        logic ok;
        sv = prim[row][col];
        ok = (sv >= thr);
        for (int dr = -1; dr <= 1; dr++) begin
            for (int dc = -1; dc <= 1; dc++) begin
                rr = int'(row) + dr;
                cc = int'(col) + dc;
                if (rr >= 0 && rr < NPE && cc >= 0 && cc < NPP)
                    nv = prim[RIW'(rr)][CIW'(cc)];
                else
                    nv = '0;
                if (dr < 0 || (dr == 0 && dc < 0)) begin
                    if (!(sv > nv)) ok = 1'b0;
                end else if (dr > 0 || dc > 0) begin
                    if (!(sv >= nv)) ok = 1'b0;
                end
            end
        end
        is_seed = ok;
    end

endmodule

// File: rtl/jet_clusterer.sv
module jet_clusterer
    import jet_pkg::*;
#(
    parameter int NTE = 12,
    parameter int NTP = 12,
    parameter int TW  = 8,
    parameter int EW  = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [NTE*NTP*TW-1:0]  towers,
    input  logic [1:0]             win_sel,
    input  logic [EW-1:0]          seed_thr,
    output logic                   jet_valid,
    output logic [EW-1:0]          jet_et,
    output logic [$clog2(NTE)-1:0] jet_eta,
    output logic [$clog2(NTP)-1:0] jet_phi,
    output logic                   done
);
    localparam int NPE = NTE / 2;
    localparam int NPP = NTP / 2;
    localparam int RIW = $clog2(NPE);
    localparam int CIW = $clog2(NPP);

    clu_state_e state_q, state_d;

    logic [NTE*NTP*TW-1:0] tw_q;
    logic [1:0]            sel_q;
    logic [EW-1:0]         thr_q;
    logic [EW-1:0]         prim_c [NPE][NPP];
    logic [1:0]            sub_c  [NPE][NPP];
    logic [EW-1:0]         prim_q [NPE][NPP];
    logic [1:0]            sub_q  [NPE][NPP];
    logic [RIW-1:0]        r_q;
    logic [CIW-1:0]        c_q;
    logic [EW-1:0]         wsum;
    logic                  seed_hit;
    logic                  last_cell;

    jet_prim_builder #(.NTE(NTE), .NTP(NTP), .TW(TW), .EW(EW)) u_prim (
        .towers (tw_q),
        .prim   (prim_c),
        .sub    (sub_c)
    );

    jet_window_eval #(.NPE(NPE), .NPP(NPP), .EW(EW), .RIW(RIW), .CIW(CIW)) u_win (
        .prim    (prim_q),
        .row     (r_q),
        .col     (c_q),
        .sel     (sel_q),
        .thr     (thr_q),
        .win_sum (wsum),
        .is_seed (seed_hit)
    );

    assign last_cell = (r_q == RIW'(NPE - 1)) && (c_q == CIW'(NPP - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = S_LOAD;
            S_LOAD: state_d = S_SCAN;
            S_SCAN: if (last_cell) state_d = S_DONE;
            S_DONE: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // captured crossing data (no reset needed)
    always_ff @(posedge clk) begin
        if (state_q == S_IDLE && start) begin
            tw_q  <= towers;
            sel_q <= win_sel;
            thr_q <= seed_thr;
        end
        if (state_q == S_LOAD) begin
            prim_q <= prim_c;
            sub_q  <= sub_c;
        end
    end

    // outputs and scan counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            jet_valid <= 1'b0;
            jet_et    <= '0;
            jet_eta   <= '0;
            jet_phi   <= '0;
            done      <= 1'b0;
            r_q       <= '0;
            c_q       <= '0;
        end else begin
            jet_valid <= 1'b0;
            done      <= 1'b0;
            unique case (state_q)
                S_IDLE: ;
                S_LOAD: begin
                    r_q <= '0;
                    c_q <= '0;
                end
                S_SCAN: begin
                    jet_valid <= seed_hit;
                    jet_et    <= wsum;
                    jet_eta   <= {r_q, sub_q[r_q][c_q][1]};
                    jet_phi   <= {c_q, sub_q[r_q][c_q][0]};
                    if (c_q == CIW'(NPP - 1)) begin
                        c_q <= '0;
                        r_q <= r_q + 1'b1;
                    end else begin
                        c_q <= c_q + 1'b1;
                    end
                end
                S_DONE: done <= 1'b1;
            endcase
        end
    end

    // R9: end-of-crossing flag lasts one cycle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: no jet in the done cycle
    assert_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && jet_valid));

    // R10: configuration held while scanning
    assert_cfg_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SCAN) |-> ($stable(sel_q) && $stable(thr_q)));

    // R10: nothing emitted while idle
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> !jet_valid);

    // R8: scan visits cells in raster order, one per cycle
    assert_raster_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SCAN && $past(state_q) == S_SCAN) |->
        (int'(r_q) * NPP + int'(c_q) == int'($past(r_q)) * NPP + int'($past(c_q)) + 1));

endmodule

// File: tb/sim_jet_clusterer.sv
module sim_jet_clusterer;
    localparam int NTE = 12;
    localparam int NTP = 12;
    localparam int TW  = 8;
    localparam int EW  = 10;
    localparam int NPE = NTE / 2;
    localparam int NPP = NTP / 2;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  start = 1'b0;
    logic [NTE*NTP*TW-1:0] towers = '0;
    logic [1:0]            win_sel = '0;
    logic [EW-1:0]         seed_thr = '0;
    logic                  jet_valid;
    logic [EW-1:0]         jet_et;
    logic [3:0]            jet_eta;
    logic [3:0]            jet_phi;
    logic                  done;

    jet_clusterer #(.NTE(NTE), .NTP(NTP), .TW(TW), .EW(EW)) u0 (
        .clk, .rst_n, .start, .towers, .win_sel, .seed_thr,
        .jet_valid, .jet_et, .jet_eta, .jet_phi, .done
    );

    always #10 clk = ~clk;

    int          n_chk = 0;
    int          n_bad = 0;
    int          exp_done = 0;
    int          grid [NTE][NTP];
    logic [31:0] expq [$];
    string       cur_req = "R1";

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void clear_grid();
        for (int e = 0; e < NTE; e++)
            for (int p = 0; p < NTP; p++) grid[e][p] = 0;
    endfunction

    function automatic int prim_at(input int r, input int c);
        int s;
        if (r < 0 || r >= NPE || c < 0 || c >= NPP) return 0;   // R7
        s = grid[2*r][2*c] + grid[2*r][2*c+1] + grid[2*r+1][2*c] + grid[2*r+1][2*c+1];
        return (s > 1023) ? 1023 : s;
    endfunction

    // expected jets from the requirements (R1..R8)
    task automatic build_expected(input int sel, input int thr);
        int lo, hi, sv, nv, sum, bt, be, bp;
        bit ok;
        lo = (sel <= 1) ? -1 : -2;
        hi = (sel == 0) ? 1 : 2;
        for (int r = 0; r < NPE; r++) begin
            for (int c = 0; c < NPP; c++) begin
                sv = prim_at(r, c);
                ok = (sv >= thr);
                for (int dr = -1; dr <= 1; dr++)
                    for (int dc = -1; dc <= 1; dc++) begin
                        nv = prim_at(r + dr, c + dc);
                        if (dr < 0 || (dr == 0 && dc < 0)) begin
                            if (!(sv > nv)) ok = 0;
                        end else if (dr > 0 || dc > 0) begin
                            if (!(sv >= nv)) ok = 0;
                        end
                    end
                if (ok) begin
                    sum = 0;
                    for (int dr = lo; dr <= hi; dr++)
                        for (int dc = lo; dc <= hi; dc++) sum += prim_at(r + dr, c + dc);
                    if (sum > 1023) sum = 1023;
                    bt = -1; be = 0; bp = 0;
                    for (int k = 0; k < 4; k++)
                        if (grid[2*r + k/2][2*c + k%2] > bt) begin
                            bt = grid[2*r + k/2][2*c + k%2];
                            be = 2*r + k/2;
                            bp = 2*c + k%2;
                        end
                    expq.push_back({8'(be), 8'(bp), 16'(sum)});
                end
            end
        end
    endtask

    task automatic load_towers();
        for (int e = 0; e < NTE; e++)
            for (int p = 0; p < NTP; p++) towers[(e*NTP + p)*TW +: TW] = TW'(grid[e][p]);
    endtask

    task automatic run(input int sel, input int thr, input bit disturb, input string req);
        int guard;
        cur_req = req;
        build_expected(sel, thr);
        load_towers();
        win_sel  = 2'(sel);
        seed_thr = EW'(thr);
        @(negedge clk) start = 1'b1;
        exp_done++;
        @(negedge clk) start = 1'b0;
        if (disturb) begin
            // R10: later start and input changes must be ignored
            repeat (5) @(negedge clk);
            towers   = '0;
            win_sel  = 2'd0;
            seed_thr = '0;
            start    = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        guard = 0;
        while (exp_done > 0 && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 500) begin
            check(0, req, "watchdog waiting for done", guard, 0);
            exp_done = 0;
            expq.delete();
        end
        repeat (disturb ? 60 : 3) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        logic [31:0] e;
        if (rst_n) begin
            if (jet_valid) begin
                if (expq.size() == 0) begin
                    check(0, cur_req, "unexpected jet et", int'(jet_et), -1);
                end else begin
                    e = expq.pop_front();
                    check(jet_et == EW'(e[15:0]), cur_req, "jet et", int'(jet_et), int'(e[15:0]));
                    check(jet_eta == 4'(e[31:24]) && jet_phi == 4'(e[23:16]), "R8",
                          "jet position eta*16+phi", int'(jet_eta)*16 + int'(jet_phi),
                          int'(e[31:24])*16 + int'(e[23:16]));
                end
            end
            if (done) begin
                check(exp_done > 0, "R9", "done pulses pending", exp_done, 1);
                check(expq.size() == 0, "R9", "jets left at done", expq.size(), 0);
                if (exp_done > 0) exp_done--;
            end
        end
    end

    initial begin
        #(20 * 200000);
        check(0, "R9", "global watchdog", 0, 1);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        check(jet_valid == 1'b0, "R11", "jet_valid in reset", int'(jet_valid), 0);
        check(done == 1'b0, "R11", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(jet_valid == 1'b0 && done == 1'b0, "R11", "outputs after reset",
              int'(jet_valid) + int'(done), 0);

        // R1: single hot tower, position to tower precision
        clear_grid();
        grid[5][6] = 40;
        run(1, 10, 0, "R1");

        // R2 / R3: asymmetric blob under each window size
        clear_grid();
        grid[4][4] = 90; grid[4][5] = 30;
        grid[2][2] = 7;  grid[8][8] = 11; grid[9][2] = 5; grid[0][9] = 13;
        grid[6][7] = 20;
        run(0, 20, 0, "R2");
        run(1, 20, 0, "R3");
        run(2, 20, 0, "R3");
        run(3, 20, 0, "R2");

        // R5: equal adjacent primitives, only the earlier one is kept
        clear_grid();
        grid[4][4] = 50; grid[4][6] = 50;
        grid[8][3] = 60; grid[10][3] = 60;
        run(1, 1, 0, "R5");

        // R4: threshold equal passes, one below fails
        clear_grid();
        grid[2][2] = 100; grid[8][8] = 99;
        run(0, 100, 0, "R4");

        // R6: saturation of the window sum
        for (int e = 0; e < NTE; e++)
            for (int p = 0; p < NTP; p++) grid[e][p] = 255;
        run(2, 0, 0, "R6");

        // R7: corner seed with out-of-grid window
        clear_grid();
        grid[0][0] = 100; grid[11][11] = 80; grid[2][1] = 9;
        run(2, 5, 0, "R7");

        // R10: start while busy is ignored
        clear_grid();
        grid[6][6] = 70; grid[1][10] = 30;
        run(1, 10, 1, "R10");

        // R1: sparse random grids over all sizes
        for (int t = 0; t < 8; t++) begin
            clear_grid();
            for (int k = 0; k < 20; k++)
                grid[$urandom_range(NTE-1)][$urandom_range(NTP-1)] = int'($urandom_range(255));
            run(t % 3, int'($urandom_range(60)), 0, "R1");
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule